// File: doc/BRIEF.md
# CAN Bus Driver Protection Supervisor

This block guards the two bus drivers of a two-channel CAN transceiver. Transmit requests from the local controller and from an expansion link, and the outputs of the bus receiver comparators, each pass through their own dominant time-out timer. A stuck dominant level on any of these paths therefore turns recessive after a fixed number of clock cycles. The timer only re-arms after its input has been recessive for at least one cycle.

For each channel the block debounces a raw short-to-battery flag, which comes from the comparator on the bus low wire. A confirmed short switches off only that channel's driver, and its receiver keeps working. An over-temperature input switches off both drivers and leaves the rest of the path untouched. A low channel enable makes the driver behave as if recessive were being sent, and it also masks that channel's receiver. A synchronous power-on reset holds every counter cleared and every output recessive.

All signals in this block use dominant = 1 and recessive = 0. Real comparators, the temperature sensor and driver slope control sit outside the block and arrive as plain digital inputs.

Top module: `can_drv_guard`

## Requirements
- R1: Each transmit input (bit 0 = local controller, bit 1 = expansion link) has an independent timer. The input level sampled at a clock edge appears on `tx_dom_o` of the same bit right after that edge, unless the timer has expired.
- R2: Once a timer's input has been sampled dominant on TDOM_CYC consecutive edges, its output is recessive from the next dominant sample on. It stays recessive until the input has been sampled recessive at least once, after which the timer re-arms.
- R3: Each receiver path applies the same time-out to the comparator level ANDed with the channel enable, and presents the result on `rx_dom_o` one cycle after sampling.
- R4: While a channel enable is sampled 0, that channel's `rx_dom_o` is recessive one cycle later, whatever the comparator reports.
- R5: `bat_short_o` of a channel rises only after the raw short input has been sampled 1 on SC_SET_CYC consecutive edges. It falls only after the input has been sampled 0 on SC_CLR_CYC consecutive edges. A sample that agrees with the current flag restarts the count.
- R6: While `bat_short_o` of a channel is 1, that channel's `drv_on_o` is 0 from the following cycle on. The other channel's driver and both receiver paths are unaffected.
- R7: An over-temperature input sampled 1 forces both `drv_on_o` bits to 0 two cycles later. The transmit and receive outputs keep following their inputs.
- R8: A channel enable sampled 0 forces that channel's `drv_on_o` to 0 two cycles later.
- R9: Two cycles after sampling, `drv_on_o` of a channel is 1 exactly when at least one filtered transmit output is dominant and the channel is enabled, free of a confirmed short, and not over temperature.
- R10: While `por_i` is sampled 1, every counter is cleared and all outputs are 0 (recessive, driver off, no short) from the next cycle on. All other inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Synchronous power-on reset, active high |
| tx_dom_i | input | NTX | Raw transmit requests, 1 = dominant (bit 0 local, bit 1 expansion) |
| rx_dom_i | input | NCH | Receiver comparator levels per channel, 1 = dominant |
| en_i | input | NCH | Channel enables, 1 = enabled |
| bat_short_i | input | NCH | Raw short-to-battery comparator flags per channel |
| hot_i | input | 1 | Over-temperature flag |
| tx_dom_o | output | NTX | Time-out filtered transmit requests |
| rx_dom_o | output | NCH | Enable-gated, time-out filtered receive levels |
| bat_short_o | output | NCH | Debounced short-to-battery flags |
| drv_on_o | output | NCH | Driver-on controls per channel |

## Verification
A stuck or miscounted timer shows up on `tx_dom_o` or `rx_dom_o` as a dominant run that ends one or more cycles early or late. The error therefore becomes visible at most TDOM_CYC + 1 cycles after the run starts. A debounce counter that fails to restart on a glitch moves the edge of `bat_short_o`, and two cycles later it makes the wrong driver go quiet. A wrong gating term on the drivers appears on `drv_on_o` within two cycles of the input change. The bench compares every output against its own model on every cycle, so any such divergence is reported in the cycle it first appears.

// File: rtl/can_guard_pkg.sv
package can_guard_pkg;
  // bits needed to hold the values 0..maxval
  function automatic int cnt_bits(input int maxval);
    return (maxval < 1) ? 1 : $clog2(maxval + 1);
  endfunction

  localparam int TX_LOCAL = 0;
  localparam int TX_EXPAND = 1;
endpackage

// File: rtl/dom_timeout.sv
module dom_timeout #(
  parameter int LIMIT = 40
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dom_i,
  output logic dom_o
);
  localparam int CW = can_guard_pkg::cnt_bits(LIMIT);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q <= '0;
      dom_o <= 1'b0;
    end else if (!dom_i) begin
      run_q <= '0;
      dom_o <= 1'b0;
    end else if (run_q != CMAX) begin
      run_q <= run_q + 1'b1;
      dom_o <= 1'b1;
    end else begin
      dom_o <= 1'b0;
    end
  end
endmodule

// File: rtl/short_debounce.sv
module short_debounce #(
  parameter int SET_CNT = 12,
  parameter int CLR_CNT = 20
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic raw_i,
  output logic flag_o
);
  localparam int BIG = (SET_CNT > CLR_CNT) ? SET_CNT : CLR_CNT;
  localparam int CW = can_guard_pkg::cnt_bits(BIG);
  localparam logic [CW-1:0] SET_LAST = CW'(SET_CNT - 1);
  localparam logic [CW-1:0] CLR_LAST = CW'(CLR_CNT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  assign last = flag_o ? CLR_LAST : SET_LAST;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else if (raw_i == flag_o) begin
      cnt_q <= '0;
    end else if (cnt_q == last) begin
      cnt_q  <= '0;
      flag_o <= raw_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/drv_gate.sv
module drv_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic any_tx_i,
  input  logic en_i,
  input  logic short_i,
  input  logic hot_i,
  output logic on_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) on_o <= 1'b0;
    else       on_o <= any_tx_i & en_i & ~short_i & ~hot_i;
  end
endmodule

// File: rtl/can_drv_guard.sv
module can_drv_guard #(
  parameter int NCH        = 2,
  parameter int NTX        = 2,
  parameter int TDOM_CYC   = 40,
  parameter int SC_SET_CYC = 12,
  parameter int SC_CLR_CYC = 20
) (
  input  logic           clk_i,
  input  logic           por_i,
  input  logic [NTX-1:0] tx_dom_i,
  input  logic [NCH-1:0] rx_dom_i,
  input  logic [NCH-1:0] en_i,
  input  logic [NCH-1:0] bat_short_i,
  input  logic           hot_i,
  output logic [NTX-1:0] tx_dom_o,
  output logic [NCH-1:0] rx_dom_o,
  output logic [NCH-1:0] bat_short_o,
  output logic [NCH-1:0] drv_on_o
);
  logic [NCH-1:0] en_q;
  logic           hot_q;
  logic           any_tx;

  // stage-one copies of enable and temperature, aligned with the filters
  always_ff @(posedge clk_i) begin
    if (por_i) begin
      en_q  <= '0;
      hot_q <= 1'b0;
    end else begin
      en_q  <= en_i;
      hot_q <= hot_i;
    end
  end

  assign any_tx = |tx_dom_o;

  for (genvar i = 0; i < NTX; i++) begin : g_tx
    dom_timeout #(.LIMIT(TDOM_CYC)) u_tmo (
      .clk_i (clk_i),
      .rst_i (por_i),
      .dom_i (tx_dom_i[i]),
      .dom_o (tx_dom_o[i])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic rx_gated;
    assign rx_gated = rx_dom_i[c] & en_i[c];

    dom_timeout #(.LIMIT(TDOM_CYC)) u_rx_tmo (
      .clk_i (clk_i),
      .rst_i (por_i),
      .dom_i (rx_gated),
      .dom_o (rx_dom_o[c])
    );

    short_debounce #(.SET_CNT(SC_SET_CYC), .CLR_CNT(SC_CLR_CYC)) u_deb (
      .clk_i  (clk_i),
      .rst_i  (por_i),
      .raw_i  (bat_short_i[c]),
      .flag_o (bat_short_o[c])
    );

    drv_gate u_gate (
      .clk_i    (clk_i),
      .rst_i    (por_i),
      .any_tx_i (any_tx),
      .en_i     (en_q[c]),
      .short_i  (bat_short_o[c]),
      .hot_i    (hot_q),
      .on_o     (drv_on_o[c])
    );
  end
endmodule

// File: rtl/can_drv_guard_chk.sv
module can_drv_guard_chk #(
  parameter int NCH        = 2,
  parameter int NTX        = 2,
  parameter int TDOM_CYC   = 40
) (
  input logic           clk_i,
  input logic           por_i,
  input logic [NTX-1:0] tx_dom_i,
  input logic [NCH-1:0] en_i,
  input logic [NCH-1:0] bat_short_i,
  input logic           hot_i,
  input logic [NTX-1:0] tx_dom_o,
  input logic [NCH-1:0] rx_dom_o,
  input logic [NCH-1:0] bat_short_o,
  input logic [NCH-1:0] drv_on_o
);
  // R10: reset clears every output on the following cycle
  p_por_quiet_r10: assert property (@(posedge clk_i)
    por_i |=> (tx_dom_o == '0 && rx_dom_o == '0 && drv_on_o == '0 && bat_short_o == '0));

  // R7: over temperature silences both drivers two cycles later
  p_hot_off_r7: assert property (@(posedge clk_i) disable iff (por_i)
    $past(hot_i, 2) |-> drv_on_o == '0);

  for (genvar i = 0; i < NTX; i++) begin : g_txc
    int run_q;
    always_ff @(posedge clk_i) begin
      if (por_i)                           run_q <= 0;
      else if (!tx_dom_o[i])               run_q <= 0;
      else if (run_q <= TDOM_CYC)          run_q <= run_q + 1;
    end
    // R1: a dominant output needs a dominant input on the previous edge
    p_tx_origin_r1: assert property (@(posedge clk_i) disable iff (por_i)
      tx_dom_o[i] |-> $past(tx_dom_i[i]));
    // R2: no dominant run on an output exceeds the time-out
    p_tx_cap_r2: assert property (@(posedge clk_i) disable iff (por_i)
      run_q <= TDOM_CYC);
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chc
    // R4: disabled receiver reads recessive
    p_rx_gate_r4: assert property (@(posedge clk_i) disable iff (por_i)
      !$past(en_i[c]) |-> !rx_dom_o[c]);
    // R8: disabled channel has its driver off
    p_dis_drv_r8: assert property (@(posedge clk_i) disable iff (por_i)
      !$past(en_i[c], 2) |-> !drv_on_o[c]);
    // R6: confirmed short keeps its driver off
    p_sc_drv_r6: assert property (@(posedge clk_i) disable iff (por_i)
      $past(bat_short_o[c]) |-> !drv_on_o[c]);
    // R5: the debounced flag only ever moves toward the raw level
    p_sc_dir_r5: assert property (@(posedge clk_i) disable iff (por_i)
      (!$past(por_i) && !$stable(bat_short_o[c])) |-> bat_short_o[c] == $past(bat_short_i[c]));
  end
endmodule

bind can_drv_guard can_drv_guard_chk #(
  .NCH(NCH), .NTX(NTX), .TDOM_CYC(TDOM_CYC)
) u_chk (
  .clk_i       (clk_i),
  .por_i       (por_i),
  .tx_dom_i    (tx_dom_i),
  .en_i        (en_i),
  .bat_short_i (bat_short_i),
  .hot_i       (hot_i),
  .tx_dom_o    (tx_dom_o),
  .rx_dom_o    (rx_dom_o),
  .bat_short_o (bat_short_o),
  .drv_on_o    (drv_on_o)
);

// File: tb/can_drv_guard_tb_top.sv
module can_drv_guard_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH = 2;
  localparam int NTX = 2;
  localparam int TD = 20;
  localparam int ST = 6;
  localparam int CL = 9;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic hot = 1'b0;
  logic alt = 1'b0;
  logic [NTX-1:0] tx_set = '0;
  logic [NTX-1:0] alt_pat = 2'b01;
  logic [NCH-1:0] rx = '0;
  logic [NCH-1:0] en = '0;
  logic [NCH-1:0] bshort = '0;
  logic [NTX-1:0] tx_in;
  logic [NTX-1:0] tx_o;
  logic [NCH-1:0] rx_o, sc_o, drv_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) alt_pat <= ~alt_pat;
  assign tx_in = alt ? alt_pat : tx_set;

  can_drv_guard #(
    .NCH(NCH), .NTX(NTX), .TDOM_CYC(TD), .SC_SET_CYC(ST), .SC_CLR_CYC(CL)
  ) dut_i (
    .clk_i(clk), .por_i(por), .tx_dom_i(tx_in), .rx_dom_i(rx), .en_i(en),
    .bat_short_i(bshort), .hot_i(hot), .tx_dom_o(tx_o), .rx_dom_o(rx_o),
    .bat_short_o(sc_o), .drv_on_o(drv_o)
  );

  // reference model built from the requirements
  bit [NTX-1:0] m_tx;
  bit [NCH-1:0] m_rx, m_sc, m_en, m_drv;
  bit m_hot;
  int m_tcnt[NTX];
  int m_rcnt[NCH];
  int m_scnt[NCH];

  always @(posedge clk) begin
    if (por) begin
      m_tx = '0; m_rx = '0; m_sc = '0; m_en = '0; m_drv = '0; m_hot = 0;
      for (int i = 0; i < NTX; i++) m_tcnt[i] = 0;
      for (int c = 0; c < NCH; c++) begin m_rcnt[c] = 0; m_scnt[c] = 0; end
    end else begin
      for (int c = 0; c < NCH; c++)
        m_drv[c] = m_en[c] & !m_sc[c] & !m_hot & (|m_tx);
      for (int i = 0; i < NTX; i++) begin
        if (!tx_in[i]) begin m_tx[i] = 0; m_tcnt[i] = 0; end
        else if (m_tcnt[i] < TD) begin m_tx[i] = 1; m_tcnt[i]++; end
        else m_tx[i] = 0;
      end
      for (int c = 0; c < NCH; c++) begin
        if (!(rx[c] & en[c])) begin m_rx[c] = 0; m_rcnt[c] = 0; end
        else if (m_rcnt[c] < TD) begin m_rx[c] = 1; m_rcnt[c]++; end
        else m_rx[c] = 0;
        if (bshort[c] == m_sc[c]) m_scnt[c] = 0;
        else begin
          m_scnt[c]++;
          if (m_scnt[c] == (m_sc[c] ? CL : ST)) begin m_sc[c] = bshort[c]; m_scnt[c] = 0; end
        end
      end
      m_en = en;
      m_hot = hot;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1/R2 transmit filter vs model", tx_o, m_tx);
      chk("R3/R4 receive filter vs model", rx_o, m_rx);
      chk("R5 short debounce vs model", sc_o, m_sc);
      chk("R9 driver control vs model", drv_o, m_drv);
    end
  end

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0ffee));
    // R10: reset with every input dominant
    por = 1; tx_set = '1; rx = '1; en = '1; bshort = '1; hot = 1;
    cyc(4);
    chk("R10 tx outputs in reset", tx_o, 0);
    chk("R10 rx outputs in reset", rx_o, 0);
    chk("R10 drivers in reset", drv_o, 0);
    chk("R10 short flags in reset", sc_o, 0);
    tx_set = '0; rx = '0; bshort = '0; hot = 0; en = 2'b11;
    cyc(1);
    por = 0;
    cmp_on = 1;
    cyc(3);

    // R1 R2 R9: local request held past the time-out, then re-armed
    tx_set = 2'b01;
    for (int k = 1; k <= TD + 3; k++) begin
      cyc(1);
      chk("R2 local timer run", tx_o[0], (k <= TD) ? 1 : 0);
      chk("R9 driver follows filtered request", drv_o, (k >= 2 && k <= TD + 1) ? 3 : 0);
    end
    tx_set = 2'b00; cyc(1);
    chk("R2 output recessive after release", tx_o[0], 0);
    tx_set = 2'b01; cyc(1);
    chk("R2 timer re-armed after one recessive cycle", tx_o[0], 1);
    tx_set = 2'b00; cyc(2);

    // R1: independent timers for local and expansion inputs
    tx_set = 2'b01; cyc(5);
    tx_set = 2'b11; cyc(TD - 4);
    chk("R1 independent timers", tx_o, 2'b10);
    tx_set = 2'b00; cyc(2);

    // R5 R6: short on channel 0 with a glitch, alternating requests keep drivers busy
    alt = 1; cyc(4);
    chk("R9 alternating requests hold drivers on", drv_o, 3);
    bshort = 2'b01; cyc(ST - 1);
    bshort = 2'b00; cyc(1);
    chk("R5 glitch blocks flag", sc_o, 0);
    bshort = 2'b01;
    for (int k = 1; k <= ST + 1; k++) begin
      cyc(1);
      if (k == ST - 1) chk("R5 flag not yet set", sc_o, 0);
      if (k == ST) chk("R5 flag set after full count", sc_o, 1);
      if (k == ST + 1) chk("R6 only shorted driver off", drv_o, 2'b10);
    end
    rx = 2'b01; cyc(1);
    chk("R6 receiver of shorted channel works", rx_o, 2'b01);
    rx = 2'b00;
    bshort = 2'b00;
    for (int k = 1; k <= CL + 1; k++) begin
      cyc(1);
      if (k == CL - 1) chk("R5 flag still held", sc_o, 1);
      if (k == CL) chk("R5 flag cleared after full count", sc_o, 0);
      if (k == CL + 1) chk("R6 driver restored", drv_o, 3);
    end

    // R7: over temperature
    hot = 1; rx = 2'b10; cyc(2);
    chk("R7 both drivers off when hot", drv_o, 0);
    chk("R7 transmit path still active", (tx_o != 0) ? 1 : 0, 1);
    chk("R7 receive path still active", rx_o, 2'b10);
    hot = 0; rx = 2'b00; cyc(2);
    chk("R7 drivers back after cooling", drv_o, 3);

    // R3 R4 R8: channel 1 disabled
    en = 2'b01; rx = 2'b11; cyc(1);
    chk("R3 R4 receiver gated by enable", rx_o, 2'b01);
    cyc(1);
    chk("R8 disabled driver off", drv_o, 2'b01);
    en = 2'b11; rx = 2'b00; alt = 0; tx_set = 2'b00; cyc(3);

    // random phase
    for (int n = 0; n < 5000; n++) begin
      int flip;
      flip = ((n / 250) % 2 == 0) ? 3 : 40;
      alt = ($urandom_range(7) == 0) ? ~alt : alt;
      if ($urandom_range(15) == 0) tx_set = NTX'($urandom);
      if ($urandom_range(11) == 0) rx = NCH'($urandom);
      if ($urandom_range(flip) == 0) bshort[$urandom_range(NCH - 1)] ^= 1'b1;
      if ($urandom_range(150) == 0) hot = ~hot;
      if ($urandom_range(90) == 0) en = NCH'($urandom);
      por = ($urandom_range(1200) == 0);
      cyc(1);
    end
    por = 0;
    cyc(2);
    cmp_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule